// File: doc/BRIEF.md
# Macro Instruction Sequencer

This block steps through a short program of 32-bit macro instructions held in an external program memory. It reads the word at its program counter each cycle and splits it into operation and operand fields. It also owns the eight-entry register file that the instructions name. Arithmetic, bit-field work, external reads and the routing of results (register write, parameter fetch, method sends) are done by a neighbouring execution block. The sequencer hands that block the instruction word and both source operands. It then waits for the block's ready, and writes back whatever value the block returns.

Control flow is handled here alone. Conditional branches may carry a delay slot: after a taken branch, one more instruction runs before the jump. An annul bit on the branch removes that slot. An exit flag also has a delay slot: the instruction after it runs, and then the program halts with a one-cycle done pulse. Three conditions stop the program with a sticky error flag: an illegal operation, a branch placed in a delay slot, and a fetch past the program length.

A run starts with a single-cycle start pulse while the block is idle. The first macro parameter is supplied alongside that pulse.

Top module: `macro_seq_core`

## Requirements
- R1: A start pulse while idle clears every register and sets the program counter to 0. It loads register 1 with `first_param_i` and raises `busy_o` from the next cycle. The first instruction is then fetched at address 0.
- R2: Bits [2:0] of a word select the operation. Bit 7 is the exit flag, [10:8] the destination, [13:11] source A and [16:14] source B. A signed 18-bit immediate sits in [31:14]. For every operation other than 7 (branch) and 6 (illegal), `exec_valid_o` is raised with the word and the two source register values. On acceptance, `wb_data_i` is written to the destination when `wb_en_i` is high.
- R3: Register 0 always reads as zero, and writes aimed at it are discarded.
- R4: A branch (operation 7) tests source A. With bit 4 clear it is taken when the value is zero; with bit 4 set it is taken when the value is nonzero. A taken branch goes to its own address plus the signed immediate, counted in words. A branch that is not taken continues at the next address.
- R5: A taken branch with bit 5 clear runs exactly one following instruction (its delay slot) before the redirect.
- R6: A taken branch with bit 5 set redirects at once, and the following instruction is not run.
- R7: An instruction with the exit flag, outside a delay slot, lets the next instruction run as a delay slot. The block then halts, pulses `done_o` for one cycle and drops `busy_o` in that same cycle.
- R8: An exit flag on an instruction that is running in a delay slot has no effect.
- R9: Operation 6, a branch in a delay slot, or a program counter at or beyond `prog_len_i` stops the run: `error_o` is set and `busy_o` drops, with no `done_o` pulse. `error_o` stays high until the next start.
- R10: While `exec_valid_o` is high and `exec_ready_i` low, the instruction is held. The program counter does not move and nothing is written back.
- R11: After reset `busy_o`, `done_o`, `error_o` and `exec_valid_o` are low.
- R12: Each instruction takes one cycle when not stalled. A run of n executed instructions keeps `busy_o` high for exactly n cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle start pulse, honoured while idle |
| first_param_i | input | 32 | First macro parameter, loaded into register 1 at start |
| prog_len_i | input | PC_W+1 | Number of valid program words |
| imem_addr_o | output | PC_W | Program memory word address (current program counter) |
| imem_rdata_i | input | 32 | Program word at `imem_addr_o`, same cycle |
| busy_o | output | 1 | A program is running |
| done_o | output | 1 | One-cycle pulse on normal exit |
| error_o | output | 1 | Sticky fault flag, cleared by start |
| exec_valid_o | output | 1 | An instruction is offered to the execution block |
| exec_instr_o | output | 32 | Instruction word being offered |
| exec_opa_o | output | 32 | Value of source A register |
| exec_opb_o | output | 32 | Value of source B register |
| exec_ready_i | input | 1 | Execution block accepts the offered instruction |
| wb_en_i | input | 1 | Write `wb_data_i` to the destination on acceptance |
| wb_data_i | input | 32 | Write-back value from the execution block |

## Verification
The delicate overlap is a delay slot whose instruction is stalled by the handshake. In that case the slot's retirement and the pending redirect or halt must land in the same cycle, and no earlier. The bench provokes it by holding `exec_ready_i` low for several cycles exactly on the slot address of a taken loop branch, and separately on the exit slot. The run is judged by the operand values observed at later addresses and by the skipped address never being offered. The busy time must grow by exactly the number of stall cycles. A second overlap is an exit flag that appears inside a branch slot. It is judged by whether execution continues at the branch target rather than halting.

// File: rtl/macro_seq_pkg.sv
// Package: shared encoding constants and decoded-instruction type for the
// macro instruction sequencer. Assumes a fixed 32-bit instruction word.
package macro_seq_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 18;
    localparam int REG_AW  = 3;

    // Operation selector in bits [2:0]
    typedef enum logic [2:0] {
        OP_ALU      = 3'd0,
        OP_ADDI     = 3'd1,
        OP_XINS     = 3'd2,
        OP_XSHL_IMM = 3'd3,
        OP_XSHL_REG = 3'd4,
        OP_EXTREAD  = 3'd5,
        OP_ILLEGAL  = 3'd6,
        OP_BRANCH   = 3'd7
    } op_e;

    // Decoded fields of one instruction word
    typedef struct packed {
        op_e                op;
        logic               exit_f;
        logic [REG_AW-1:0]  dst;
        logic [REG_AW-1:0]  src_a;
        logic [REG_AW-1:0]  src_b;
        logic               br_nz;
        logic               annul;
        logic [IMM_W-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/mseq_decode.sv
// Module: mseq_decode
// Splits an instruction word into its fields. Purely combinational.
// Assumes the field layout fixed in macro_seq_pkg; bits 3 and 6 are
// consumed by the execution block only.
module mseq_decode
    import macro_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic unused_bits;

    // Field extraction
    always_comb begin
        dec_o.op     = op_e'(instr_i[2:0]);
        dec_o.br_nz  = instr_i[4];
        dec_o.annul  = instr_i[5];
        dec_o.exit_f = instr_i[7];
        dec_o.dst    = instr_i[10:8];
        dec_o.src_a  = instr_i[13:11];
        dec_o.src_b  = instr_i[16:14];
        dec_o.imm    = instr_i[31:14];
    end

    assign unused_bits = instr_i[3] ^ instr_i[6];
endmodule

// File: rtl/mseq_regfile.sv
// Module: mseq_regfile
// Register file with two combinational read ports and one write port.
// Entry 0 is hard-wired to zero. A clear pulse zeroes all entries and
// loads entry 1 with load_val_i; clear takes priority over a write.
module mseq_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_a_addr_i,
    input  logic [AW-1:0]     rd_b_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    output logic [DATA_W-1:0] rd_b_data_o
);
    logic [DATA_W-1:0] rf_view [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign rf_view[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            // Holds one register; cleared or loaded at start, else written
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (clear_i) begin
                    q <= (g == 1) ? load_val_i : '0;
                end else if (wr_en_i && (wr_addr_i == AW'(g))) begin
                    q <= wr_data_i;
                end
            end
            assign rf_view[g] = q;
        end
    end

    // Read port multiplexers
    assign rd_a_data_o = rf_view[rd_a_addr_i];
    assign rd_b_data_o = rf_view[rd_b_addr_i];

    assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (rf_view[1] == $past(load_val_i)));

endmodule

// File: rtl/mseq_ctrl.sv
// Module: mseq_ctrl
// Run state, program counter, delay-slot tracking and fault detection.
// Assumes the program word and register operand for the current counter
// are valid in the same cycle (combinational memory and register reads).
module mseq_ctrl
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [PC_W:0]   prog_len_i,
    input  op_e             op_i,
    input  logic            exit_i,
    input  logic            br_nz_i,
    input  logic            annul_i,
    input  logic [PC_W-1:0] offset_i,
    input  logic [31:0]     cond_val_i,
    input  logic            exec_ready_i,
    output logic [PC_W-1:0] pc_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            error_o,
    output logic            issue_o,
    output logic            retire_exec_o,
    output logic            clear_o
);
    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    state_e          state_q;
    logic [PC_W-1:0] pc_q, slot_target_q;
    logic            in_slot_q, slot_redir_q, slot_exit_q;
    logic            done_q, error_q;

    logic            running, fetch_ok, is_br, fault, retire, taken;
    logic [PC_W-1:0] pc_inc, br_target;

    // Fault, issue and branch evaluation for the current word
    always_comb begin
        running   = (state_q == ST_RUN);
        fetch_ok  = ({1'b0, pc_q} < prog_len_i);
        is_br     = (op_i == OP_BRANCH);
        fault     = running && (!fetch_ok || (op_i == OP_ILLEGAL) || (is_br && in_slot_q));
        issue_o   = running && !fault && !is_br;
        retire    = (issue_o && exec_ready_i) || (running && !fault && is_br);
        taken     = is_br && (br_nz_i ? (cond_val_i != '0) : (cond_val_i == '0));
        pc_inc    = pc_q + 1'b1;
        br_target = pc_q + offset_i;
    end

    // Sequencing state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            pc_q          <= '0;
            slot_target_q <= '0;
            in_slot_q     <= 1'b0;
            slot_redir_q  <= 1'b0;
            slot_exit_q   <= 1'b0;
            done_q        <= 1'b0;
            error_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!running) begin
                if (start_i) begin
                    state_q   <= ST_RUN;
                    pc_q      <= '0;
                    in_slot_q <= 1'b0;
                    error_q   <= 1'b0;
                end
            end else if (fault) begin
                state_q <= ST_IDLE;
                error_q <= 1'b1;
            end else if (retire) begin
                if (in_slot_q) begin
                    in_slot_q <= 1'b0;
                    pc_q      <= slot_redir_q ? slot_target_q : pc_inc;
                    if (slot_exit_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end else if (taken && annul_i) begin
                    pc_q <= br_target;
                end else if (taken) begin
                    pc_q          <= pc_inc;
                    in_slot_q     <= 1'b1;
                    slot_redir_q  <= 1'b1;
                    slot_exit_q   <= 1'b0;
                    slot_target_q <= br_target;
                end else if (exit_i) begin
                    pc_q         <= pc_inc;
                    in_slot_q    <= 1'b1;
                    slot_redir_q <= 1'b0;
                    slot_exit_q  <= 1'b1;
                end else begin
                    pc_q <= pc_inc;
                end
            end
        end
    end

    assign pc_o          = pc_q;
    assign busy_o        = running;
    assign done_o        = done_q;
    assign error_o       = error_q;
    assign retire_exec_o = issue_o && exec_ready_i;
    assign clear_o       = !running && start_i;

    assert_fault_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (error_o && !busy_o && !done_o));

    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && !exec_ready_i) |=> (busy_o && $stable(pc_q) && !done_o));

    assert_slot_opened_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !fault && taken && !annul_i && !in_slot_q) |=> (in_slot_q && busy_o));

    assert_annul_no_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !fault && taken && annul_i) |=> (!in_slot_q && pc_q == $past(br_target)));

    assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !error_o));

endmodule

// File: rtl/macro_seq_core.sv
// Module: macro_seq_core (top)
// In-order macro instruction sequencer: fetch, decode, register file and
// control flow. Non-branch instructions are offered to an external
// execution block, which returns an optional write-back value.
// Assumes program memory answers in the same cycle as the address.
module macro_seq_core
    import macro_seq_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int DATA_W = 32,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] first_param_i,
    input  logic [PC_W:0]     prog_len_i,
    output logic [PC_W-1:0]   imem_addr_o,
    input  logic [INSTR_W-1:0] imem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic              exec_valid_o,
    output logic [INSTR_W-1:0] exec_instr_o,
    output logic [DATA_W-1:0] exec_opa_o,
    output logic [DATA_W-1:0] exec_opb_o,
    input  logic              exec_ready_i,
    input  logic              wb_en_i,
    input  logic [DATA_W-1:0] wb_data_i
);
    dec_t              dec;
    logic [DATA_W-1:0] rd_a, rd_b;
    logic              retire_exec, clear;
    logic              unused_imm;

    mseq_decode u_decode (
        .instr_i (imem_rdata_i),
        .dec_o   (dec)
    );

    mseq_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .load_val_i  (first_param_i),
        .wr_en_i     (retire_exec && wb_en_i),
        .wr_addr_i   (dec.dst),
        .wr_data_i   (wb_data_i),
        .rd_a_addr_i (dec.src_a),
        .rd_b_addr_i (dec.src_b),
        .rd_a_data_o (rd_a),
        .rd_b_data_o (rd_b)
    );

    mseq_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .prog_len_i    (prog_len_i),
        .op_i          (dec.op),
        .exit_i        (dec.exit_f),
        .br_nz_i       (dec.br_nz),
        .annul_i       (dec.annul),
        .offset_i      (dec.imm[PC_W-1:0]),
        .cond_val_i    (32'(rd_a)),
        .exec_ready_i  (exec_ready_i),
        .pc_o          (imem_addr_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .error_o       (error_o),
        .issue_o       (exec_valid_o),
        .retire_exec_o (retire_exec),
        .clear_o       (clear)
    );

    assign exec_instr_o = imem_rdata_i;
    assign exec_opa_o   = rd_a;
    assign exec_opb_o   = rd_b;
    assign unused_imm   = ^dec.imm[IMM_W-1:PC_W];

    assert_offer_only_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid_o |-> busy_o);

    assert_quiet_after_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !error_o && !exec_valid_o));

endmodule

// File: tb/test_macro_seq_core.sv
module test_macro_seq_core;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 0, rst_n = 0, start = 0;
    logic [31:0] param = 0;
    logic [8:0]  plen = 0;
    logic [7:0]  addr;
    logic [31:0] rdata, instr, opa, opb, wbdata;
    logic        busy, done, err, xvalid, xready;
    logic [31:0] pmem [32];

    int n_run = 0, n_fail = 0, wd = 0;
    int          stall_addr = -1, stall_len = 0, hold_cnt = 0;
    logic        stall_clr = 0;
    logic [31:0] cap [32];
    int          hits [32];
    int          cyc;
    logic        saw_done, saw_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rdata  = pmem[addr[4:0]];
    assign xready = !(xvalid && int'(addr) == stall_addr && hold_cnt < stall_len);
    assign wbdata = opa + {{14{instr[31]}}, instr[31:14]};

    macro_seq_core i_macro_seq_core (
        .clk(clk), .rst_n(rst_n), .start_i(start), .first_param_i(param),
        .prog_len_i(plen), .imem_addr_o(addr), .imem_rdata_i(rdata),
        .busy_o(busy), .done_o(done), .error_o(err),
        .exec_valid_o(xvalid), .exec_instr_o(instr), .exec_opa_o(opa),
        .exec_opb_o(opb), .exec_ready_i(xready), .wb_en_i(1'b1), .wb_data_i(wbdata)
    );

    always @(posedge clk) begin
        if (stall_clr) hold_cnt <= 0;
        else if (xvalid && int'(addr) == stall_addr && hold_cnt < stall_len) hold_cnt <= hold_cnt + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog act=%0d exp=<%0d", wd, 190000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic [31:0] enc_addi(input [2:0] dst, input [2:0] sa, input int imm, input bit ex);
        logic [31:0] v = imm;
        return {v[17:0], sa, dst, ex, 3'd1, 1'b0, 3'd1};
    endfunction

    function automatic [31:0] enc_br(input [2:0] sa, input bit nz, input bit an, input bit ex, input int imm);
        logic [31:0] v = imm;
        return {v[17:0], sa, 3'd0, ex, 1'b0, an, nz, 1'b0, 3'd7};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) pmem[i] = enc_addi(0, 0, 0, 0);
    endtask

    // Starts one run and watches it until busy drops
    task automatic run(input logic [31:0] p, input int len);
        for (int i = 0; i < 32; i++) begin cap[i] = 32'hDEAD; hits[i] = 0; end
        @(negedge clk); stall_clr = 1; start = 1; param = p; plen = 9'(len);
        @(negedge clk); stall_clr = 0; start = 0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (xvalid && xready) begin cap[addr[4:0]] = opa; hits[addr[4:0]]++; end
            @(negedge clk);
        end
        saw_done = done; saw_err = err;
    endtask

    task automatic load_loop();
        clear_mem();
        pmem[0] = enc_addi(2, 0, 0, 0);
        pmem[1] = enc_addi(2, 2, 3, 0);
        pmem[2] = enc_addi(1, 1, -1, 0);
        pmem[3] = enc_br(1, 1, 0, 0, -2);
        pmem[4] = enc_addi(3, 3, 1, 0);
        pmem[5] = enc_addi(5, 2, 0, 1);
        pmem[6] = enc_addi(6, 3, 0, 0);
        pmem[7] = enc_addi(7, 7, 100, 0);
    endtask

    localparam logic [31:0] V_N    [4] = '{32'd1, 32'd2, 32'd5, 32'd9};
    localparam logic [31:0] V_SUM  [4] = '{32'd3, 32'd6, 32'd15, 32'd27};
    localparam logic [31:0] V_SLOT [4] = '{32'd1, 32'd2, 32'd5, 32'd9};
    localparam logic [31:0] V_CYC  [4] = '{32'd7, 32'd11, 32'd23, 32'd39};

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", 32'(busy), 0);
        chk("R11 done", 32'(done), 0);
        chk("R11 error", 32'(err), 0);
        chk("R11 exec_valid", 32'(xvalid), 0);
        @(negedge clk); rst_n = 1;

        // Table: counted loop with delay-slot branch and exit slot
        load_loop();
        for (int k = 0; k < 4; k++) begin
            run(V_N[k], 8);
            chk("R4 R5 loop sum (r2 at exit)", cap[5], V_SUM[k]);
            chk("R5 slot count (r3)", cap[6], V_SLOT[k]);
            chk("R12 busy cycles", 32'(cyc), V_CYC[k]);
            chk("R7 done pulse", 32'(saw_done), 1);
            chk("R7 nothing after exit slot", 32'(hits[7]), 0);
        end

        // R10: stall on branch delay slot, then on exit slot
        stall_addr = 4; stall_len = 3;
        run(2, 8);
        chk("R10 stalled slot sum", cap[5], 6);
        chk("R10 stalled slot count", cap[6], 2);
        chk("R10 cycles grow by stall", 32'(cyc), 14);
        stall_addr = 6; stall_len = 4;
        run(1, 8);
        chk("R10 stalled exit slot r3", cap[6], 1);
        chk("R10 R7 exit delayed", 32'(cyc), 11);
        chk("R7 done after stalled slot", 32'(saw_done), 1);
        stall_addr = -1; stall_len = 0;

        // R6, R1: annulled always-taken branch; registers cleared at start
        clear_mem();
        pmem[0] = enc_br(0, 0, 1, 0, 3);
        pmem[1] = enc_addi(5, 0, 7, 0);
        pmem[3] = enc_addi(2, 5, 0, 1);
        pmem[4] = enc_addi(3, 1, 0, 0);
        run(32'h1234, 8);
        chk("R6 annulled slot not run", 32'(hits[1]), 0);
        chk("R1 r5 cleared by start", cap[3], 0);
        chk("R1 r1 holds parameter", cap[4], 32'h1234);
        chk("R6 cycles", 32'(cyc), 3);

        // R8: exit flag inside branch slot ignored; R4 nonzero test
        clear_mem();
        pmem[0] = enc_br(1, 1, 0, 0, 3);
        pmem[1] = enc_addi(2, 0, 5, 1);
        pmem[2] = enc_addi(2, 0, 9, 0);
        pmem[3] = enc_addi(3, 2, 0, 1);
        pmem[4] = enc_addi(0, 0, 0, 0);
        run(1, 8);
        chk("R8 runs on to target", cap[3], 5);
        chk("R4 skipped address", 32'(hits[2]), 0);
        chk("R8 cycles", 32'(cyc), 4);

        // R3: register 0 discards writes; R2 operands
        clear_mem();
        pmem[0] = enc_addi(0, 1, 5, 0);
        pmem[1] = enc_addi(2, 0, 0, 1);
        pmem[2] = enc_addi(3, 1, 0, 0);
        run(77, 8);
        chk("R3 r0 reads zero", cap[1], 0);
        chk("R2 source A operand", cap[2], 77);

        // R9 faults
        clear_mem();
        pmem[0] = 32'h0000_0006;
        run(1, 8);
        chk("R9 illegal op error", 32'(saw_err), 1);
        chk("R9 illegal op no done", 32'(saw_done), 0);
        chk("R9 illegal op cycles", 32'(cyc), 1);
        clear_mem();
        pmem[0] = enc_addi(0, 0, 0, 1);
        pmem[1] = enc_br(0, 0, 0, 0, 1);
        run(1, 8);
        chk("R9 branch in slot error", 32'(saw_err), 1);
        chk("R9 branch in slot cycles", 32'(cyc), 2);
        clear_mem();
        run(1, 2);
        chk("R9 length fault error", 32'(saw_err), 1);
        chk("R9 length fault cycles", 32'(cyc), 3);

        // R9: error cleared by next start
        load_loop();
        run(1, 8);
        chk("R9 error cleared by start", 32'(saw_err), 0);
        chk("R7 done after recovery", 32'(saw_done), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule